// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block is the device-side end of a four-wire serial link. While the active-low select is held low, it shifts the data-in line into a 22-bit capture register on each rising serial clock edge. It also counts those edges. When select rises, the count decides what happens to the frame. A frame with fewer than 22 edges does nothing. With 22 or more edges, the last 22 bits captured are decoded as one command word.

A command can write a byte into a small bank of control registers, or it can ask for a byte to be read back. The byte that was asked for comes out on data-out during the next frame. In every other frame, data-out carries the latest conversion result. That value is taken from a parallel input at the moment select falls.

The serial pins are oversampled by the system clock through two-stage synchronizers. Data-out changes after falling serial clock edges, so the host samples it on rising edges, most significant bit first.

Top module: `spi_cmd_frame_dec`

## Requirements
- R1: After reset every control register reads zero, and data-out is low.
- R2: A frame of exactly 22 clocks is decoded at the select rising edge. With opcode 6'h02 in bits 21:16, the frame writes bits 7:0 into the register addressed by bits 15:8.
- R3: A frame of fewer than 22 clocks is a no-op. No register changes, no read is armed, and the following frame carries the conversion result.
- R4: A frame of more than 22 clocks decodes only the last 22 bits shifted in. Earlier bits have no effect, and any clock count is accepted.
- R5: Opcodes other than 6'h01 (read) and 6'h02 (write) leave the registers unchanged and arm no read.
- R6: The frame after a read command (opcode 6'h01, address in bits 15:8) returns the addressed byte in response bits 21:14, followed by 14 zero bits, most significant bit first.
- R7: When no read is armed, a frame returns the conversion result in response bits 21:6, followed by 6 zero bits. The result is the value present at the select falling edge, and bits clocked after the 22nd are zero.
- R8: An armed read is consumed by exactly one frame. The frame after that returns the conversion result again.
- R9: Data-out stays low while select is high. Addresses at or beyond the register count ignore writes and read back as zero.
- R10: Serial clock and data-in activity while select is high has no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data toward the block |
| conv_data | input | CONV_W | Latest conversion result |
| sdo | output | 1 | Serial data toward the host, registered |
| ctrl_q | output | NREG*REG_W | Control register bank, with register i in bits i*REG_W upward |

## Verification
On every cycle, the checker confirms several rules. Data-out stays low while the block is deselected. A frame shorter than 22 clocks leaves the registers stable and arms no read. The edge counter holds once it is saturated. An armed read is dropped at the next select fall. A full-length write lands in the addressed register. The bench scenarios show the rest, which is the actual bit stream. They check the read-back byte placed in the following frame, the conversion value frozen at select fall, and the fact that only the trailing 22 bits of a long frame count. They sweep every short length, a range of long lengths, every opcode, and addresses inside and outside the bank.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int FRAME_W = 22;
  localparam int OP_W    = 6;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [OP_W-1:0] OP_READ  = 6'h01;
  localparam logic [OP_W-1:0] OP_WRITE = 6'h02;
endpackage

// File: rtl/scd_sync_edge.sv
module scd_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_act,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  // index 0 is the newest sample, index 2 the previous synchronized one
  logic [2:0] cs_q;
  logic [2:0] ck_q;
  logic [1:0] di_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 3'b111;
      ck_q <= 3'b000;
      di_q <= 2'b00;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      ck_q <= {ck_q[1:0], sclk};
      di_q <= {di_q[0], sdi};
    end
  end

  assign cs_act   = ~cs_q[1];
  assign cs_fall  =  cs_q[2] & ~cs_q[1];
  assign cs_rise  = ~cs_q[2] &  cs_q[1];
  assign sck_rise = cs_act & ~ck_q[2] &  ck_q[1];
  assign sck_fall = cs_act &  ck_q[2] & ~ck_q[1];
  assign sdi_s    = di_q[1];
endmodule

// File: rtl/scd_shifter.sv
module scd_shifter
  import spicmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi_s,
  input  logic [FRAME_W-1:0] resp,
  output logic [FRAME_W-1:0] isr_word,
  output logic [CNT_W-1:0]   frm_cnt,
  output logic               sdo
);
  logic [FRAME_W-1:0] isr;
  logic [FRAME_W-1:0] osr;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= '0;
      osr <= '0;
      cnt <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
      osr <= resp;
    end else begin
      if (sck_rise) begin
        isr <= {isr[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
      if (cs_rise)       osr <= '0;
      else if (sck_fall) osr <= {osr[FRAME_W-2:0], 1'b0};
    end
  end

  assign isr_word = isr;
  assign frm_cnt  = cnt;
  assign sdo      = osr[FRAME_W-1];
endmodule

// File: rtl/scd_regbank.sv
module scd_regbank
  import spicmd_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int REG_W = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_stb,
  input  logic [FRAME_W-1:0]    cmd_word,
  input  logic                  cs_fall,
  output logic                  rd_pend,
  output logic [REG_W-1:0]      rd_data,
  output logic [NREG*REG_W-1:0] ctrl_q
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [REG_W-1:0]  regs [NREG];
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0]  wdat;
  logic [IDX_W-1:0]  idx;
  logic              in_rng;

  assign op     = cmd_word[FRAME_W-1 -: OP_W];
  assign addr   = cmd_word[FRAME_W-OP_W-1 -: ADDR_W];
  assign wdat   = cmd_word[REG_W-1:0];
  assign idx    = addr[IDX_W-1:0];
  assign in_rng = int'(addr) < NREG;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rd_pend <= 1'b0;
      rd_data <= '0;
    end else begin
      if (cs_fall) rd_pend <= 1'b0;
      if (cmd_stb) begin
        if (op == OP_WRITE && in_rng) regs[idx] <= wdat;
        if (op == OP_READ) begin
          rd_pend <= 1'b1;
          rd_data <= in_rng ? regs[idx] : '0;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign ctrl_q[g*REG_W +: REG_W] = regs[g];
  end
endmodule

// File: rtl/spi_cmd_frame_dec.sv
module spi_cmd_frame_dec
  import spicmd_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int REG_W  = DATA_W,
  parameter int CONV_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic [CONV_W-1:0]     conv_data,
  output logic                  sdo,
  output logic [NREG*REG_W-1:0] ctrl_q
);
  logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall, sdi_s;
  logic [FRAME_W-1:0] isr_word;
  logic [FRAME_W-1:0] resp;
  logic [CNT_W-1:0]   frm_cnt;
  logic               cmd_stb;
  logic               rd_pend;
  logic [REG_W-1:0]   rd_data;

  scd_sync_edge u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
  );

  scd_shifter u_shift (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
    .resp(resp), .isr_word(isr_word), .frm_cnt(frm_cnt), .sdo(sdo)
  );

  // a frame counts as a command once at least a full word was clocked in
  assign cmd_stb = cs_rise && (frm_cnt >= CNT_FULL);

  scd_regbank #(.NREG(NREG), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_word(isr_word),
    .cs_fall(cs_fall), .rd_pend(rd_pend), .rd_data(rd_data), .ctrl_q(ctrl_q)
  );

  assign resp = rd_pend ? {rd_data, {(FRAME_W-REG_W){1'b0}}}
                        : {conv_data, {(FRAME_W-CONV_W){1'b0}}};

  // cs_act feeds only the bound checker
  logic unused_ok;
  assign unused_ok = cs_act;
endmodule

// File: rtl/scd_checker.sv
module scd_checker
  import spicmd_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int REG_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs_act,
  input logic                  cs_fall,
  input logic                  cs_rise,
  input logic                  sck_rise,
  input logic [CNT_W-1:0]      frm_cnt,
  input logic [FRAME_W-1:0]    isr_word,
  input logic                  rd_pend,
  input logic [NREG*REG_W-1:0] ctrl_q,
  input logic                  sdo
);
  logic             wr_seen;
  logic [7:0]       wr_idx;
  logic [REG_W-1:0] wr_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= 1'b0;
      wr_idx  <= '0;
      wr_dat  <= '0;
    end else begin
      wr_seen <= cs_rise && frm_cnt >= CNT_FULL
                 && isr_word[FRAME_W-1 -: OP_W] == OP_WRITE
                 && int'(isr_word[15:8]) < NREG;
      wr_idx  <= isr_word[15:8];
      wr_dat  <= isr_word[REG_W-1:0];
    end
  end

  // R9
  sdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |-> !sdo);

  // R3
  short_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && frm_cnt < CNT_FULL) |=> (!rd_pend && $stable(ctrl_q)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && frm_cnt == CNT_SAT) |=> frm_cnt == CNT_SAT);

  // R8
  pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> !rd_pend);

  // R2
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    wr_seen |-> ctrl_q[int'(wr_idx)*REG_W +: REG_W] == wr_dat);

  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> $stable(frm_cnt));
endmodule

bind spi_cmd_frame_dec scd_checker #(.NREG(NREG), .REG_W(REG_W)) u_scd_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .sck_rise(sck_rise), .frm_cnt(frm_cnt), .isr_word(isr_word),
  .rd_pend(rd_pend), .ctrl_q(ctrl_q), .sdo(sdo)
);

// File: tb/test_spi_cmd_frame_dec.sv
module test_spi_cmd_frame_dec;
  localparam int CLK_PERIOD = 10;
  localparam int NREG   = 4;
  localparam int CONV_W = 16;
  localparam int PH     = 6;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [CONV_W-1:0] conv_data = '0;
  logic              sdo;
  logic [NREG*8-1:0] ctrl_q;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_frame_dec #(.NREG(NREG), .CONV_W(CONV_W)) i_spi_cmd_frame_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .conv_data(conv_data), .sdo(sdo), .ctrl_q(ctrl_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = din[i];
      waitn(PH);
      dout[i] = sdo;
      sclk = 1'b1;
      waitn(PH);
      sclk = 1'b0;
    end
    waitn(PH);
    cs_n = 1'b1;
    sdi  = 1'b0;
    waitn(8);
  endtask

  function automatic logic [63:0] cmd(input logic [5:0] op, input logic [7:0] a, input logic [7:0] d);
    return {42'd0, op, a, d};
  endfunction

  function automatic logic [63:0] flat();
    logic [63:0] v = '0;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  function automatic logic [63:0] conv_resp(input logic [CONV_W-1:0] c);
    return {42'd0, c, 6'd0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] dout, din;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    waitn(5);
    rst = 1'b0;
    waitn(4);
    // R1 reset state
    chk("R1 sdo", {63'd0, sdo}, 64'd0);
    chk("R1 regs", {32'd0, ctrl_q}, 64'd0);
    conv_data = 16'h1234;
    frame(22, cmd(6'h01, 8'd0, 8'd0), dout);
    chk("R7 first conv", dout, conv_resp(16'h1234));
    frame(22, 64'd0, dout);
    chk("R1 reg0 readback", dout, {42'd0, 8'h00, 14'd0});

    // R2 R6 R8 R9 sweep over addresses, including out of range
    for (int a = 0; a < NREG + 2; a++) begin
      d = 8'(a * 37 + 5);
      frame(22, cmd(6'h02, 8'(a), d), dout);
      if (a < NREG) mdl[a] = d;
      chk("R2 write", {32'd0, ctrl_q}, flat());
      frame(22, cmd(6'h01, 8'(a), 8'h00), dout);
      conv_data = 16'(a * 4099 + 7);
      frame(22, 64'd0, dout);
      chk("R6 R9 read response", dout, {42'd0, (a < NREG) ? mdl[a] : 8'h00, 14'd0});
      frame(22, 64'd0, dout);
      chk("R8 back to conv", dout, conv_resp(conv_data));
    end

    // R3 every short length
    for (int n = 1; n < 22; n++) begin
      frame(n, cmd(6'h02, 8'd0, ~mdl[0]), dout);
      chk("R3 short write", {32'd0, ctrl_q}, flat());
      frame(n, cmd(6'h01, 8'd1, 8'd0), dout);
      conv_data = 16'(n * 311);
      frame(22, 64'd0, dout);
      chk("R3 short read not armed", dout, conv_resp(conv_data));
    end

    // R4 long frames with junk prefix; R7 tail zeros
    for (int n = 23; n <= 40; n++) begin
      d = 8'(n * 11);
      din = ({64{1'b1}} << 22) | cmd(6'h02, 8'(n % NREG), d);
      conv_data = 16'(n * 1021 + 3);
      frame(n, din, dout);
      mdl[n % NREG] = d;
      chk("R4 long write", {32'd0, ctrl_q}, flat());
      chk("R7 long response", dout, conv_resp(conv_data) << (n - 22));
    end

    // R5 every other opcode is a no-op
    for (int op = 0; op < 64; op++) begin
      if (op == 1 || op == 2) continue;
      frame(22, cmd(6'(op), 8'd0, 8'hA5), dout);
      chk("R5 unknown op regs", {32'd0, ctrl_q}, flat());
      conv_data = 16'(op * 977);
      frame(22, 64'd0, dout);
      chk("R5 unknown op not armed", dout, conv_resp(conv_data));
    end

    // R7 conversion value frozen at select fall
    conv_data = 16'hBEEF;
    fork
      frame(22, 64'd0, dout);
      begin waitn(30); conv_data = 16'h0F0F; end
    join
    chk("R7 frozen at select fall", dout, conv_resp(16'hBEEF));

    // R10 R9 activity while deselected
    din = cmd(6'h02, 8'd2, 8'h3C);
    for (int i = 21; i >= 0; i--) begin
      sdi = din[i];
      waitn(3);
      chk("R9 sdo idle", {63'd0, sdo}, 64'd0);
      sclk = 1'b1;
      waitn(3);
      sclk = 1'b0;
    end
    waitn(8);
    chk("R10 no effect deselected", {32'd0, ctrl_q}, flat());
    conv_data = 16'h5AA5;
    frame(22, 64'd0, dout);
    chk("R10 next frame conv", dout, conv_resp(16'h5AA5));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule